// File: doc/BRIEF.md
# Partial Precomputation Decision Feedback Equalizer

This block turns a stream of feedforward-filtered samples into a stream of binary (2-level pulse amplitude) decisions. It cancels trailing intersymbol interference by subtracting a weighted sum of past decisions before slicing. The default has six feedback taps. Only the two newest taps are speculated: for each of the four sign patterns of the two most recent decisions, a candidate is formed ahead of time. In the deciding cycle, the real history picks one candidate and the slicer reads its sign, so the recursive loop holds just one multiplexer and a sign bit.

The four older taps cannot change within the loop. Their contribution is reduced through a carry-save chain together with the incoming sample, and a single two-input add finishes it. All of this happens one cycle before the decision. The history bits it reads are taken one position deeper whenever the previous sample is still waiting to be decided in that same cycle.

Samples come in with a valid strobe, and decisions leave with a valid strobe. A two-state controller tracks the candidate stage. ST_IDLE means the stage is empty. ST_HOLD means it holds a sample whose decision is committed at the next edge. The transitions are:
- IDLE→HOLD (load) on a valid sample.
- HOLD→HOLD (stream) on a valid sample.
- HOLD→IDLE (drain) when no sample arrives.
- IDLE→IDLE (wait) when no sample arrives.

The weights are expected to be steady while samples are in flight.

Top module: `dfe_ppc_top`

## Requirements
- R1: During reset and at the first edge after release, out_valid is 0 and out_dec is 0. The decision history is all −1, so the first samples after reset see every past decision as −1.
- R2: For sample n, y = x[n] − Σ_{k=0}^{L−1} w_k·d[n−1−k]. Tap k sits at in_weights[8k+7:8k], signed two's complement, and tap 0 weighs the newest decision. out_dec = 1 encodes +1 and is produced exactly when y ≥ 0; out_dec = 0 encodes −1.
- R3: A sample captured at clock edge E has its decision on out_dec, with out_valid high for that one cycle, right after edge E+1.
- R4: While out_valid is low, out_dec keeps the value of the last decision.
- R5: Samples on consecutive cycles give the same decisions, bit for bit, as an unpipelined recursive model.
- R6: Idle gaps of any length between samples leave the decision sequence unchanged.
- R7: The decision history changes only in a cycle in which a decision is produced.
- R8: A pre-slicer value of exactly zero gives a +1 decision.
- R9: Full-scale samples (−512, 511) with full-scale weights (−128, 127) are decided without wrap-around.
- R10: Weights changed while no sample is in flight apply to the next sample accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_sample carries a sample this cycle |
| in_sample | input | 10 | Feedforward output sample, signed |
| in_weights | input | 48 | Six signed 8-bit feedback weights, tap 0 in the low byte |
| out_valid | output | 1 | out_dec carries a new decision |
| out_dec | output | 1 | Decision: 1 = +1, 0 = −1 |

## Verification
The risky overlap is at a single edge during streaming. There, the decision for sample n−1 is committed and the history shifts, while the older-tap sum for sample n is formed from that same history and must reach one position deeper. The bench provokes this with long back-to-back runs, and then sends the same kinds of traffic with random bubbles, so that both alignments of the older-tap sum are exercised. Each cycle, the valid strobe and the decision are compared against a behavioural recursive model advanced once per accepted sample, and any mismatch in either alignment shows up as a wrong decision.

// File: rtl/dfe_ppc_pkg.sv
`timescale 1ns/1ps
package dfe_ppc_pkg;
    localparam int DFE_TAPS  = 6;
    localparam int DFE_PRE   = 2;
    localparam int DFE_WGT_W = 8;
    localparam int DFE_SMP_W = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } dfe_st_e;
endpackage

// File: rtl/dfe_sign_term.sv
`timescale 1ns/1ps
module dfe_sign_term #(
    parameter int WGT_W = 8,
    parameter int ACC_W = 14
) (
    input  logic [WGT_W-1:0] weight,
    input  logic             dec,
    output logic [ACC_W-1:0] term
);
    logic [ACC_W-1:0] wext;

    assign wext = {{(ACC_W-WGT_W){weight[WGT_W-1]}}, weight};
    // decision +1 subtracts the weight, decision -1 adds it
    assign term = dec ? (~wext + 1'b1) : wext;
endmodule

// File: rtl/dfe_csa_sum.sv
`timescale 1ns/1ps
module dfe_csa_sum #(
    parameter int NUM = 5,
    parameter int W   = 14
) (
    input  logic [NUM*W-1:0] ops,
    output logic [W-1:0]     sum
);
    localparam int STEPS = NUM - 2;

    logic [W-1:0] s_v [STEPS+1];
    logic [W-1:0] c_v [STEPS+1];

    assign s_v[0] = ops[0 +: W];
    assign c_v[0] = ops[W +: W];

    for (genvar i = 0; i < STEPS; i++) begin : g_csa
        logic [W-1:0] a_v;
        assign a_v      = ops[(i+2)*W +: W];
        assign s_v[i+1] = s_v[i] ^ c_v[i] ^ a_v;
        assign c_v[i+1] = ((s_v[i] & c_v[i]) | (s_v[i] & a_v) | (c_v[i] & a_v)) << 1;
    end

    // single vector-merge add
    assign sum = s_v[STEPS] + c_v[STEPS];
endmodule

// File: rtl/dfe_cand_bank.sv
`timescale 1ns/1ps
module dfe_cand_bank #(
    parameter int PRE   = 2,
    parameter int WGT_W = 8,
    parameter int ACC_W = 14,
    localparam int NCAND = 1 << PRE
) (
    input  logic [ACC_W-1:0]       base,
    input  logic [PRE*WGT_W-1:0]   w_near,
    output logic [NCAND*ACC_W-1:0] cands
);
    for (genvar p = 0; p < NCAND; p++) begin : g_pat
        localparam logic [PRE-1:0] PAT = p[PRE-1:0];
        logic [(PRE+1)*ACC_W-1:0] ops;
        assign ops[0 +: ACC_W] = base;
        for (genvar j = 0; j < PRE; j++) begin : g_term
            dfe_sign_term #(.WGT_W(WGT_W), .ACC_W(ACC_W)) u_term (
                .weight (w_near[j*WGT_W +: WGT_W]),
                .dec    (PAT[j]),
                .term   (ops[(j+1)*ACC_W +: ACC_W])
            );
        end
        dfe_csa_sum #(.NUM(PRE+1), .W(ACC_W)) u_add (
            .ops (ops),
            .sum (cands[p*ACC_W +: ACC_W])
        );
    end
endmodule

// File: rtl/dfe_ppc_top.sv
`timescale 1ns/1ps
module dfe_ppc_top
    import dfe_ppc_pkg::*;
#(
    parameter int TAPS  = DFE_TAPS,
    parameter int PRE   = DFE_PRE,
    parameter int WGT_W = DFE_WGT_W,
    parameter int SMP_W = DFE_SMP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [SMP_W-1:0]      in_sample,
    input  logic [TAPS*WGT_W-1:0] in_weights,
    output logic                  out_valid,
    output logic                  out_dec
);
    localparam int MAX_W = (SMP_W > WGT_W) ? SMP_W : WGT_W;
    localparam int ACC_W = MAX_W + $clog2(TAPS + 1) + 1;
    localparam int NCAND = 1 << PRE;
    localparam int TAIL  = TAPS - PRE;

    dfe_st_e st_q, st_d;
    logic [TAPS-1:0]        hist_q;
    logic [NCAND*ACC_W-1:0] cand_q;
    logic [NCAND*ACC_W-1:0] cand_d;
    logic [ACC_W-1:0]       base;
    logic [(TAIL+1)*ACC_W-1:0] tail_ops;
    logic                   stage_full;
    logic [PRE-1:0]         sel;
    logic [ACC_W-1:0]       y_sel;
    logic                   dec_now;

    assign stage_full = (st_q == ST_HOLD);

    // older taps: sample plus tail terms, reduced outside the loop
    assign tail_ops[0 +: ACC_W] = {{(ACC_W-SMP_W){in_sample[SMP_W-1]}}, in_sample};
    for (genvar j = 0; j < TAIL; j++) begin : g_tail
        localparam int K = PRE + j;
        logic tap_dec;
        // a sample still in the candidate stage is decided at this edge,
        // so the history is one position short: read one deeper
        assign tap_dec = stage_full ? hist_q[K-1] : hist_q[K];
        dfe_sign_term #(.WGT_W(WGT_W), .ACC_W(ACC_W)) u_term (
            .weight (in_weights[K*WGT_W +: WGT_W]),
            .dec    (tap_dec),
            .term   (tail_ops[(j+1)*ACC_W +: ACC_W])
        );
    end

    dfe_csa_sum #(.NUM(TAIL+1), .W(ACC_W)) u_tail (
        .ops (tail_ops),
        .sum (base)
    );

    dfe_cand_bank #(.PRE(PRE), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_bank (
        .base   (base),
        .w_near (in_weights[PRE*WGT_W-1:0]),
        .cands  (cand_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= '0;
        end else if (in_valid) begin
            cand_q <= cand_d;
        end
    end

    // inner loop: one select by the two newest decisions, then the sign
    assign sel     = hist_q[PRE-1:0];
    assign y_sel   = cand_q[sel*ACC_W +: ACC_W];
    assign dec_now = ~y_sel[ACC_W-1];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: st_d = in_valid ? ST_HOLD : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dec   <= 1'b0;
            hist_q    <= '0;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    out_valid <= 1'b1;
                    out_dec   <= dec_now;
                    hist_q    <= {hist_q[TAPS-2:0], dec_now};
                end
                default: begin
                    out_valid <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dfe_ppc_chk.sv
`timescale 1ns/1ps
module dfe_ppc_chk #(
    parameter int TAPS = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic            out_dec,
    input logic [TAPS-1:0] hist,
    input logic            hold
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd0) |-> (!out_valid && !out_dec && hist == '0));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R4
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && !out_valid) |-> $stable(out_dec));

    // R7
    hist_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && !$past(hold)) |-> $stable(hist));
endmodule

bind dfe_ppc_top dfe_ppc_chk #(.TAPS(TAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_dec   (out_dec),
    .hist      (hist_q),
    .hold      (stage_full)
);

// File: tb/dfe_ppc_top_bench.sv
`timescale 1ns/1ps
module dfe_ppc_top_bench;
    localparam int TAPS  = 6;
    localparam int WGT_W = 8;
    localparam int SMP_W = 10;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [SMP_W-1:0]      in_sample = '0;
    logic [TAPS*WGT_W-1:0] in_weights = '0;
    logic                  out_valid;
    logic                  out_dec;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    int  wv [TAPS];
    int  rh [TAPS];
    bit  exp_v [$];
    bit  exp_d [$];
    bit  last_dec;

    always #2.5 clk = ~clk;

    dfe_ppc_top u_dfe_ppc_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_weights(in_weights), .out_valid(out_valid), .out_dec(out_dec)
    );

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // behavioural recursive model: history of +1/-1, newest at index 0
    function automatic bit ref_decide(input int x);
        int y = x;
        bit d;
        for (int k = 0; k < TAPS; k++) y -= wv[k] * rh[k];
        d = (y >= 0);
        for (int k = TAPS-1; k > 0; k--) rh[k] = rh[k-1];
        rh[0] = d ? 1 : -1;
        return d;
    endfunction

    task automatic set_w(input int a0, input int a1, input int a2,
                         input int a3, input int a4, input int a5);
        wv[0] = a0; wv[1] = a1; wv[2] = a2; wv[3] = a3; wv[4] = a4; wv[5] = a5;
        for (int k = 0; k < TAPS; k++) in_weights[k*WGT_W +: WGT_W] = wv[k][WGT_W-1:0];
    endtask

    task automatic step(input bit v, input int x, input string tag);
        bit ev, ed, expd;
        @(negedge clk);
        ev = exp_v.pop_front();
        ed = exp_d.pop_front();
        expd = ev ? ed : last_dec;
        if (ev) last_dec = ed;
        check(tag, "out_valid", int'(out_valid), int'(ev));
        check(ev ? tag : "R4", "out_dec", int'(out_dec), int'(expd));
        in_valid  = v;
        in_sample = x[SMP_W-1:0];
        exp_v.push_back(v);
        exp_d.push_back(v ? ref_decide(x) : 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: held in reset
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_dec in reset", int'(out_dec), 0);
        for (int k = 0; k < TAPS; k++) rh[k] = -1;
        last_dec = 1'b0;
        exp_v.delete(); exp_d.delete();
        exp_v.push_back(1'b0); exp_d.push_back(1'b0);
        exp_v.push_back(1'b0); exp_d.push_back(1'b0);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, tag);
    endtask

    task automatic rand_w(input int lim);
        set_w($signed($urandom_range(2*lim)) - lim, $signed($urandom_range(2*lim)) - lim,
              $signed($urandom_range(2*lim)) - lim, $signed($urandom_range(2*lim)) - lim,
              $signed($urandom_range(2*lim)) - lim, $signed($urandom_range(2*lim)) - lim);
    endtask

    initial begin
        void'($urandom(17));
        set_w(40, -30, 25, -20, 15, -10);
        do_reset();
        // R1: first decisions see an all -1 history
        idle(1, "R1");
        step(1'b1, -100, "R1");
        step(1'b1, -30, "R1");
        idle(3, "R1");

        // R2: directed single samples, isolated
        set_w(60, 0, 0, 0, 0, 0);
        step(1'b1, -50, "R2");
        idle(2, "R2");
        step(1'b1, 50, "R2");
        idle(2, "R2");
        step(1'b1, 70, "R3");
        idle(3, "R3");

        // R8: exact-zero pre-slicer value
        do_reset();
        set_w(5, 0, 0, 0, 0, 0);
        idle(1, "R8");
        step(1'b1, -5, "R8");
        step(1'b1, 5, "R8");
        set_w(0, 0, 0, 0, 0, 0);
        idle(3, "R8");
        step(1'b1, 0, "R8");
        step(1'b1, -1, "R8");
        idle(3, "R8");

        // R5: back-to-back streaming
        do_reset();
        rand_w(100);
        for (int i = 0; i < 300; i++) step(1'b1, $signed($urandom_range(600)) - 300, "R5");
        idle(3, "R5");

        // R6 and R7: random bubbles
        for (int r = 0; r < 4; r++) begin
            rand_w(100);
            idle(2, "R7");
            for (int i = 0; i < 200; i++) begin
                if ($urandom_range(2) == 0) idle($urandom_range(1, 4), "R7");
                step(1'b1, $signed($urandom_range(600)) - 300, "R6");
            end
            idle(3, "R6");
        end

        // R9: full scale
        do_reset();
        set_w(-128, -128, -128, -128, -128, -128);
        idle(1, "R9");
        for (int i = 0; i < 20; i++) step(1'b1, (i % 3 == 0) ? 511 : -512, "R9");
        idle(3, "R9");
        set_w(127, 127, 127, 127, 127, 127);
        for (int i = 0; i < 20; i++) step(1'b1, (i % 2 == 0) ? -512 : 511, "R9");
        idle(3, "R9");
        set_w(127, -128, 127, -128, 127, -128);
        for (int i = 0; i < 40; i++) step(1'b1, ($urandom_range(1) != 0) ? 511 : -512, "R9");
        idle(3, "R9");

        // R10: weights changed while idle
        for (int r = 0; r < 5; r++) begin
            rand_w(120);
            idle(1, "R10");
            for (int i = 0; i < 12; i++) step(1'b1, $signed($urandom_range(400)) - 200, "R10");
            idle(3, "R10");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule